// File: doc/BRIEF.md
# Ping-pong frame buffer swap controller

This block sits between a camera that writes pixels and a display engine that reads them. Each side has its own clock, and the two clocks are unrelated. Two external frame memory banks are shared between the sides. The camera side fills one bank while the display side reads the other. The block does not move pixel data. For each side it produces a registered write or read strobe, a bank select and a linear pixel address. The memory interface uses these to steer its own data path.

Roles swap only when two conditions hold at once. The camera side must have stored a whole frame, from pixel zero to the last pixel, in its bank. The display side must have read a whole frame and be entering its own vertical blanking. When the display is not ready, it reads its current bank again. When the camera delivers frames faster than the display can take them, the camera side holds its completed bank untouched and drops the incoming frames. The read bank therefore always holds exactly one camera frame, which removes the tear line that a swap in the middle of a frame would cause.

Completion of a frame and acceptance of a frame each cross between the clock domains as a toggle on a single bit, passed through two flip-flops. The frame size comes from two parameters, pixels per line and lines per frame. Their defaults are 640 and 480.

Top module: `pingpong_swap_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, wr_en, rd_en and rd_swap are 0, rd_bank is 0 and wr_bank is 1.
- R2: The write address restarts at 0 after every accepted rising edge of cam_vsync. Each cycle with cam_de high while a frame is being filled gives one wr_en pulse one clock later, with addresses 0, 1, 2 and so on. A frame gets at most PIX = H_PIX*V_LINES writes, and any cam_de beyond that is ignored.
- R3: wr_frame_done pulses in the same cycle as the write of address PIX-1. The bank is then complete, and no write reaches it until the display side has taken it. Camera frames that start in this interval produce no wr_en at all.
- R4: Once the display side has taken the completed bank, the next rising edge of cam_vsync flips wr_bank, and writing restarts at address 0 in the other bank.
- R5: A camera frame that ends before reaching PIX pixels is not complete. The next rising edge of cam_vsync restarts writing at address 0 in the same bank.
- R6: After a rising edge of disp_vsync, each cycle with disp_re high gives one rd_en pulse one clock later, with addresses 0, 1, 2 and so on. A frame gets at most PIX reads, and any disp_re beyond that is ignored.
- R7: At a rising edge of disp_vsync, the banks swap if two conditions hold: the previous display frame read all PIX pixels, and a complete bank is waiting. In that case rd_bank flips and rd_swap is 1 for one cycle. Both happen one clock after the edge.
- R8: At a rising edge of disp_vsync where either condition of R7 fails, rd_bank keeps its value, rd_swap stays 0, and reading restarts at address 0 of the same bank.
- R9: wr_bank changes only in the cycle after a clock edge where cam_vsync rose. rd_bank changes only in the cycle after a clock edge where disp_vsync rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Camera-side clock |
| wrst | input | 1 | Camera-side synchronous reset, active high |
| cam_vsync | input | 1 | Camera frame sync level; a rising edge starts a frame |
| cam_de | input | 1 | Camera pixel valid during active video |
| wr_en | output | 1 | Write strobe toward the frame memory |
| wr_bank | output | 1 | Bank that the camera side is writing |
| wr_addr | output | AW | Linear pixel address of the write |
| wr_frame_done | output | 1 | One-cycle pulse with the last pixel of a complete frame |
| rclk | input | 1 | Display-side clock |
| rrst | input | 1 | Display-side synchronous reset, active high |
| disp_vsync | input | 1 | Display frame sync level; a rising edge marks vertical blanking |
| disp_re | input | 1 | Display pixel request |
| rd_en | output | 1 | Read strobe toward the frame memory |
| rd_bank | output | 1 | Bank that the display side is reading |
| rd_addr | output | AW | Linear pixel address of the read |
| rd_swap | output | 1 | One-cycle pulse when the display side takes the new bank |

## Verification
The checker observes, on every clock of its own domain, the properties local to one side. Each bank select changes only right after a vsync edge on its own side. Consecutive strobes step the address by exactly one and never leave the frame. The done pulse coincides with the write of the last address. A swap pulse always comes with a flip of rd_bank. Other behaviour spans both clock domains and depends on the history of frames, and only the bench's frame sequences can show it. This covers the camera side dropping frames while its bank is held, the decision between re-reading and swapping after a partial read, a restart after an incomplete camera frame, and the bank that each side uses after every exchange.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    WR_WAIT = 2'd0,   // after reset, no bank owed to the reader yet
    WR_FILL = 2'd1,   // writing a frame into the own bank
    WR_HOLD = 2'd2,   // own bank complete, waiting for the reader to take it
    WR_FREE = 2'd3    // reader took it, flip at the next camera vsync
  } wr_state_e;

  function automatic int addr_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pps_sync2.sv
module pps_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '0;
    else     ff <= {ff[0], d};
  end

  assign q = ff[1];
endmodule

// File: rtl/pps_rise_det.sv
module pps_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/pps_wr_ctrl.sv
module pps_wr_ctrl #(
  parameter int PIX = 8,
  parameter int AW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vs_rise,
  input  logic          de,
  input  logic          ack_tog_s,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic          frame_done,
  output logic          done_tog
);
  import pps_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(PIX - 1);

  wr_state_e     state;
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= WR_WAIT;
      cnt        <= '0;
      wr_en      <= 1'b0;
      wr_bank    <= 1'b1;
      wr_addr    <= '0;
      frame_done <= 1'b0;
      done_tog   <= 1'b0;
    end else begin
      wr_en      <= 1'b0;
      frame_done <= 1'b0;
      unique case (state)
        WR_WAIT: begin
          if (vs_rise) begin
            cnt   <= '0;
            state <= WR_FILL;
          end
        end
        WR_FILL: begin
          if (vs_rise) begin
            // incomplete frame: restart the same bank
            cnt <= '0;
          end else if (de) begin
            wr_en   <= 1'b1;
            wr_addr <= cnt;
            if (cnt == LAST) begin
              frame_done <= 1'b1;
              done_tog   <= ~done_tog;
              cnt        <= '0;
              state      <= WR_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        WR_HOLD: begin
          // camera frames are dropped here; bank stays intact
          if (ack_tog_s == done_tog) state <= WR_FREE;
        end
        WR_FREE: begin
          if (vs_rise) begin
            wr_bank <= ~wr_bank;
            cnt     <= '0;
            state   <= WR_FILL;
          end
        end
        default: state <= WR_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/pps_rd_ctrl.sv
module pps_rd_ctrl #(
  parameter int PIX = 8,
  parameter int AW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vs_rise,
  input  logic          re,
  input  logic          done_tog_s,
  output logic          rd_en,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          swap,
  output logic          ack_tog
);
  localparam logic [AW-1:0] LAST = AW'(PIX - 1);

  logic [AW-1:0] cnt;
  logic          live;
  logic          consumed;
  logic          pending;

  assign pending = done_tog_s ^ ack_tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      live     <= 1'b0;
      consumed <= 1'b0;
      rd_en    <= 1'b0;
      rd_bank  <= 1'b0;
      rd_addr  <= '0;
      swap     <= 1'b0;
      ack_tog  <= 1'b0;
    end else begin
      rd_en <= 1'b0;
      swap  <= 1'b0;
      if (vs_rise) begin
        cnt      <= '0;
        live     <= 1'b1;
        consumed <= 1'b0;
        if (consumed && pending) begin
          rd_bank <= ~rd_bank;
          ack_tog <= ~ack_tog;
          swap    <= 1'b1;
        end
      end else if (re && live) begin
        rd_en   <= 1'b1;
        rd_addr <= cnt;
        if (cnt == LAST) begin
          consumed <= 1'b1;
          live     <= 1'b0;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pingpong_swap_ctrl.sv
module pingpong_swap_ctrl #(
  parameter  int H_PIX   = 640,
  parameter  int V_LINES = 480,
  localparam int PIX     = H_PIX * V_LINES,
  localparam int AW      = pps_pkg::addr_bits(PIX)
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          cam_vsync,
  input  logic          cam_de,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic          wr_frame_done,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          disp_vsync,
  input  logic          disp_re,
  output logic          rd_en,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          rd_swap
);
  logic cam_vs_rise, disp_vs_rise;
  logic done_tog, done_tog_s;
  logic ack_tog, ack_tog_s;

  pps_rise_det cam_edge_i (
    .clk(wclk), .rst(wrst), .lvl(cam_vsync), .rise(cam_vs_rise)
  );
  pps_rise_det disp_edge_i (
    .clk(rclk), .rst(rrst), .lvl(disp_vsync), .rise(disp_vs_rise)
  );

  pps_sync2 done_sync_i (
    .clk(rclk), .rst(rrst), .d(done_tog), .q(done_tog_s)
  );
  pps_sync2 ack_sync_i (
    .clk(wclk), .rst(wrst), .d(ack_tog), .q(ack_tog_s)
  );

  pps_wr_ctrl #(.PIX(PIX), .AW(AW)) wr_i (
    .clk        (wclk),
    .rst        (wrst),
    .vs_rise    (cam_vs_rise),
    .de         (cam_de),
    .ack_tog_s  (ack_tog_s),
    .wr_en      (wr_en),
    .wr_bank    (wr_bank),
    .wr_addr    (wr_addr),
    .frame_done (wr_frame_done),
    .done_tog   (done_tog)
  );

  pps_rd_ctrl #(.PIX(PIX), .AW(AW)) rd_i (
    .clk        (rclk),
    .rst        (rrst),
    .vs_rise    (disp_vs_rise),
    .re         (disp_re),
    .done_tog_s (done_tog_s),
    .rd_en      (rd_en),
    .rd_bank    (rd_bank),
    .rd_addr    (rd_addr),
    .swap       (rd_swap),
    .ack_tog    (ack_tog)
  );
endmodule

// File: rtl/pps_swap_chk.sv
module pps_swap_chk #(
  parameter int PIX = 8,
  parameter int AW  = 3
) (
  input logic          wclk,
  input logic          wrst,
  input logic          cam_vsync,
  input logic          wr_en,
  input logic          wr_bank,
  input logic [AW-1:0] wr_addr,
  input logic          wr_frame_done,
  input logic          rclk,
  input logic          rrst,
  input logic          disp_vsync,
  input logic          rd_en,
  input logic          rd_bank,
  input logic [AW-1:0] rd_addr,
  input logic          rd_swap
);
  localparam logic [AW:0] PIX_W = (AW+1)'(PIX);

  // R9
  wr_bank_vsync_chk: assert property (@(posedge wclk) disable iff (wrst)
    !$stable(wr_bank) |-> ($past(cam_vsync) && !$past(cam_vsync, 2)));

  // R9
  rd_bank_vsync_chk: assert property (@(posedge rclk) disable iff (rrst)
    !$stable(rd_bank) |-> ($past(disp_vsync) && !$past(disp_vsync, 2)));

  // R2
  wr_addr_range_chk: assert property (@(posedge wclk) disable iff (wrst)
    wr_en |-> ({1'b0, wr_addr} < PIX_W));

  // R2
  wr_addr_step_chk: assert property (@(posedge wclk) disable iff (wrst)
    (wr_en && $past(wr_en)) |-> (wr_addr == AW'($past(wr_addr) + 1'b1)));

  // R3
  wr_done_last_chk: assert property (@(posedge wclk) disable iff (wrst)
    wr_frame_done |-> (wr_en && ({1'b0, wr_addr} == PIX_W - 1'b1)));

  // R6
  rd_addr_range_chk: assert property (@(posedge rclk) disable iff (rrst)
    rd_en |-> ({1'b0, rd_addr} < PIX_W));

  // R6
  rd_addr_step_chk: assert property (@(posedge rclk) disable iff (rrst)
    (rd_en && $past(rd_en)) |-> (rd_addr == AW'($past(rd_addr) + 1'b1)));

  // R7
  rd_swap_flip_chk: assert property (@(posedge rclk) disable iff (rrst)
    rd_swap |-> (!$stable(rd_bank) && !rd_en));
endmodule

bind pingpong_swap_ctrl pps_swap_chk #(.PIX(PIX), .AW(AW)) chk_i (
  .wclk(wclk), .wrst(wrst), .cam_vsync(cam_vsync), .wr_en(wr_en),
  .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_frame_done(wr_frame_done),
  .rclk(rclk), .rrst(rrst), .disp_vsync(disp_vsync), .rd_en(rd_en),
  .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_swap(rd_swap)
);

// File: tb/pingpong_swap_ctrl_tb_top.sv
module pingpong_swap_ctrl_tb_top;
  localparam int H = 4;
  localparam int V = 2;
  localparam int NPIX = H * V;
  localparam int AW = 3;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst = 1'b1, rrst = 1'b1;
  logic cam_vsync = 1'b0, cam_de = 1'b0;
  logic disp_vsync = 1'b0, disp_re = 1'b0;
  logic wr_en, wr_bank, wr_frame_done, rd_en, rd_bank, rd_swap;
  logic [AW-1:0] wr_addr, rd_addr;

  always #2 wclk = ~wclk;   // 250 MHz camera side
  always #3.5 rclk = ~rclk; // unrelated display side

  pingpong_swap_ctrl #(.H_PIX(H), .V_LINES(V)) dut_i (
    .wclk(wclk), .wrst(wrst), .cam_vsync(cam_vsync), .cam_de(cam_de),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_frame_done(wr_frame_done),
    .rclk(rclk), .rrst(rrst), .disp_vsync(disp_vsync), .disp_re(disp_re),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_swap(rd_swap)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  int wcount, waddr_err, wdone, wexp;
  int wbank_seen;
  int rcount, raddr_err, rswap, rexp;
  int rbank_seen;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge wclk) begin
    if (!wrst && wr_en) begin
      if (int'(wr_addr) != wexp) waddr_err++;
      wexp++;
      wcount++;
      wbank_seen = int'(wr_bank);
      if (wr_frame_done) wdone++;
    end
  end

  always @(negedge rclk) begin
    if (!rrst) begin
      if (rd_en) begin
        if (int'(rd_addr) != rexp) raddr_err++;
        rexp++;
        rcount++;
        rbank_seen = int'(rd_bank);
      end
      if (rd_swap) rswap++;
    end
  end

  task automatic cam_frame(input int n);
    wcount = 0; waddr_err = 0; wdone = 0; wexp = 0; wbank_seen = -1;
    @(negedge wclk) cam_vsync = 1'b1;
    repeat (2) @(negedge wclk);
    cam_vsync = 1'b0;
    repeat (2) @(negedge wclk);
    for (int i = 0; i < n; i++) begin
      cam_de = 1'b1;
      @(negedge wclk);
    end
    cam_de = 1'b0;
    repeat (14) @(negedge wclk);
  endtask

  task automatic disp_frame(input int n);
    rcount = 0; raddr_err = 0; rswap = 0; rexp = 0; rbank_seen = -1;
    @(negedge rclk) disp_vsync = 1'b1;
    repeat (2) @(negedge rclk);
    disp_vsync = 1'b0;
    repeat (2) @(negedge rclk);
    for (int i = 0; i < n; i++) begin
      disp_re = 1'b1;
      @(negedge rclk);
    end
    disp_re = 1'b0;
    repeat (8) @(negedge rclk);
  endtask

  // {cam_n[4], exp_wcnt[4], exp_wbank, rd_n[4], exp_rcnt[4], exp_rbank, exp_swap}
  localparam int NV = 13;
  localparam logic [18:0] VEC [NV] = '{
    {4'd8,  4'd8, 1'b1, 4'd10, 4'd8, 1'b0, 1'b0}, // first frame, reader not yet done
    {4'd8,  4'd0, 1'b0, 4'd8,  4'd8, 1'b1, 1'b1}, // camera dropped, reader swaps
    {4'd5,  4'd5, 1'b0, 4'd8,  4'd8, 1'b1, 1'b0}, // partial camera frame
    {4'd8,  4'd8, 1'b0, 4'd8,  4'd8, 1'b0, 1'b1}, // restart same bank
    {4'd0,  4'd0, 1'b0, 4'd8,  4'd8, 1'b0, 1'b0}, // nothing new: re-read
    {4'd10, 4'd8, 1'b1, 4'd8,  4'd8, 1'b1, 1'b1}, // extra pixels ignored
    {4'd8,  4'd8, 1'b0, 4'd3,  4'd3, 1'b0, 1'b1}, // partial display read
    {4'd8,  4'd8, 1'b1, 4'd8,  4'd8, 1'b0, 1'b0}, // no swap after partial read
    {4'd0,  4'd0, 1'b0, 4'd8,  4'd8, 1'b1, 1'b1},
    {4'd8,  4'd8, 1'b0, 4'd8,  4'd8, 1'b0, 1'b1},
    {4'd8,  4'd8, 1'b1, 4'd0,  4'd0, 1'b0, 1'b0}, // camera only
    {4'd8,  4'd0, 1'b0, 4'd0,  4'd0, 1'b0, 1'b0}, // held bank: dropped
    {4'd0,  4'd0, 1'b0, 4'd8,  4'd8, 1'b1, 1'b1}
  };

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge rclk);
    // R1: reset state during reset
    check("R1 wr_bank", int'(wr_bank), 1);
    check("R1 rd_bank", int'(rd_bank), 0);
    check("R1 enables", int'(wr_en) + int'(rd_en) + int'(rd_swap), 0);
    @(negedge wclk) wrst = 1'b0;
    @(negedge rclk) rrst = 1'b0;
    @(negedge rclk);
    check("R1 after release", int'(wr_bank) * 2 + int'(rd_bank), 2);

    for (int v = 0; v < NV; v++) begin
      int cam_n, ew, ewb, rd_n, er, erb, es;
      string wreq;
      cam_n = int'(VEC[v][18:15]);
      ew    = int'(VEC[v][14:11]);
      ewb   = int'(VEC[v][10]);
      rd_n  = int'(VEC[v][9:6]);
      er    = int'(VEC[v][5:2]);
      erb   = int'(VEC[v][1]);
      es    = int'(VEC[v][0]);
      if (cam_n > 0) begin
        cam_frame(cam_n);
        wreq = (ew == 0) ? "R3 drop" : ((cam_n < NPIX) ? "R5 partial" : "R2 count");
        check(wreq, wcount, ew);
        check("R2 addr seq", waddr_err, 0);
        check("R3 done pulse", wdone, (ew == NPIX) ? 1 : 0);
        if (ew > 0) check("R4 wr bank", wbank_seen, ewb);
      end
      if (rd_n > 0) begin
        disp_frame(rd_n);
        check("R6 read count", rcount, er);
        check("R6 addr seq", raddr_err, 0);
        check(es ? "R7 rd bank" : "R8 rd bank", rbank_seen, erb);
        check(es ? "R7 swap pulse" : "R8 no swap", rswap, es);
      end
    end

    // R9: reads without vsync leave rd_bank alone
    begin
      int b0;
      b0 = int'(rd_bank);
      disp_re = 1'b1;
      repeat (4) @(negedge rclk);
      disp_re = 1'b0;
      @(negedge rclk);
      check("R9 rd_bank stable", int'(rd_bank), b0);
    end

    // R1: mid-run reset returns both sides to the reset state
    @(negedge wclk) wrst = 1'b1;
    @(negedge rclk) rrst = 1'b1;
    repeat (3) @(negedge rclk);
    @(negedge wclk) wrst = 1'b0;
    @(negedge rclk) rrst = 1'b0;
    @(negedge rclk);
    check("R1 re-reset", int'(wr_bank) * 2 + int'(rd_bank), 2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule